// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block moves 18-bit words between two ports, A and B, through clocked storage. Words bound for B from A are captured in a single register. Words bound for A from B take one of two routes. The first is a three-deep shift chain followed by a final output register. The second is a direct load of the final register from the B input. A route select input chooses between them, and it is looked at only when the final register loads.

The block uses one system clock. Each of the three transfer clocks is a one-cycle strobe sampled on that clock: the A-to-B load strobe, the B-to-A shift strobe and the B-to-A output strobe. Each direction has an active-low capture enable and an active-low drive enable. Instead of three-state pins, each port provides a data-out bus and a drive flag. An asynchronous active-low reset clears all storage.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst_n` is low and in the cycle after it is released, `a_out` and `b_out` are all zeros.
- R2: A system-clock edge with `ab_stb`=1 and `ab_ce_n`=0 loads `a_in` into the A-to-B register. `b_out` shows that value from then on.
- R3: An edge with `ab_ce_n`=1 or with `ab_stb`=0 leaves `b_out` unchanged.
- R4: An edge with `ba_out_stb`=1, `ba_ce_n`=0 and `ba_direct`=1 loads `b_in` straight into `a_out`. The shift chain is not touched.
- R5: With `ba_direct`=0, a word on `b_in` needs three enabled `ba_shift_stb` edges and then one enabled `ba_out_stb` edge to appear on `a_out`. Each shift edge moves the chain by one place: `b_in` goes to place 0, place 0 to place 1, and place 1 to place 2. The output edge copies place 2.
- R6: While `ba_ce_n`=1, neither strobe changes the shift chain or `a_out`.
- R7: `b_drv` is 1 exactly when `ab_oe_n`=0, and `a_drv` is 1 exactly when `ba_oe_n`=0, in the same cycle. Both registers keep capturing while drive is off.
- R8: When both B-to-A strobes are enabled on the same edge with `ba_direct`=0, `a_out` takes the value place 2 held before that edge. The chain still shifts.
- R9: `ba_direct` is used only on `ba_out_stb` edges. Changing it never alters or flushes the shift chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Word arriving on port A |
| ab_stb | input | 1 | A-to-B load strobe |
| ab_ce_n | input | 1 | A-to-B capture enable, active low |
| ab_oe_n | input | 1 | Port B drive enable, active low |
| b_in | input | 18 | Word arriving on port B |
| ba_shift_stb | input | 1 | B-to-A shift-chain strobe |
| ba_out_stb | input | 1 | B-to-A output-register strobe |
| ba_ce_n | input | 1 | B-to-A capture enable, active low, gates both strobes |
| ba_oe_n | input | 1 | Port A drive enable, active low |
| ba_direct | input | 1 | Route select: 1 direct from B, 0 from chain place 2 |
| a_out | output | 18 | Word driven onto port A |
| a_drv | output | 1 | Port A drive flag |
| b_out | output | 18 | Word driven onto port B |
| b_drv | output | 1 | Port B drive flag |

## Verification
In the chained route, a shift and an output load can fall on the same edge. The output register must then take the old contents of place 2 while the chain advances. The bench loads the three places with distinct words and fires both strobes together with `ba_ce_n` low. It expects `a_out` to equal the word that was in place 2 before the edge, and a later lone output strobe to show the word that moved up. A long sweep also raises both strobes together at random against a cycle model in the bench.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    // Route taken by the B-to-A output register when it loads.
    typedef enum logic {
        ROUTE_CHAIN  = 1'b0,
        ROUTE_DIRECT = 1'b1
    } route_e;

    localparam int unsigned XCVR_WIDTH = 18;
    localparam int unsigned XCVR_CHAIN = 3;
endpackage

// File: rtl/xcvr_ab_reg.sv
module xcvr_ab_reg #(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic         ce_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic load;
    assign load = stb & ~ce_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

    // R2: enabled strobe captures the input word
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !ce_n) |=> q == $past(d));
    // R3: no enabled strobe, no change
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb && !ce_n) |=> $stable(q));
endmodule

// File: rtl/xcvr_ba_chain.sv
module xcvr_ba_chain #(
    parameter int unsigned W     = 18,
    parameter int unsigned DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic         ce_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] tail
);
    localparam int unsigned LAST = DEPTH - 1;

    logic [DEPTH-1:0][W-1:0] place;
    logic                    shift;
    assign shift = stb & ~ce_n;

    genvar k;
    generate
        for (k = 0; k < DEPTH; k++) begin : g_place
            if (k == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        place[0] <= '0;
                    else if (shift)
                        place[0] <= d;
                end
            end else begin : g_body
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        place[k] <= '0;
                    else if (shift)
                        place[k] <= place[k-1];
                end
            end
        end
    endgenerate

    assign tail = place[LAST];

    // R5: an enabled shift puts the input word into place 0
    a_r5_head: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !ce_n) |=> place[0] == $past(d));
    // R5: and moves the older head one place on
    a_r5_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !ce_n) |=> place[DEPTH-1:1] == $past(place[DEPTH-2:0]));
    // R6/R9: without an enabled shift the chain is frozen
    a_r6_chain_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb && !ce_n) |=> $stable(place));
endmodule

// File: rtl/xcvr_ba_out.sv
module xcvr_ba_out
    import xcvr_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic         ce_n,
    input  logic         direct,
    input  logic [W-1:0] b_word,
    input  logic [W-1:0] chain_tail,
    output logic [W-1:0] q
);
    route_e       route;
    logic [W-1:0] pick;
    logic         load;

    assign route = route_e'(direct);
    assign load  = stb & ~ce_n;

    always_comb begin
        unique case (route)
            ROUTE_DIRECT: pick = b_word;
            ROUTE_CHAIN:  pick = chain_tail;
            default:      pick = chain_tail;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= pick;
    end

    // R4: direct route loads the B word
    a_r4_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !ce_n && direct) |=> q == $past(b_word));
    // R8: chained route takes place 2 as it stood before the edge
    a_r8_old_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !ce_n && !direct) |=> q == $past(chain_tail));
    // R6: output held without an enabled strobe
    a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb && !ce_n) |=> $stable(q));
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = XCVR_WIDTH,
    parameter int unsigned CHAIN = XCVR_CHAIN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic             ab_stb,
    input  logic             ab_ce_n,
    input  logic             ab_oe_n,
    input  logic [WIDTH-1:0] b_in,
    input  logic             ba_shift_stb,
    input  logic             ba_out_stb,
    input  logic             ba_ce_n,
    input  logic             ba_oe_n,
    input  logic             ba_direct,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drv,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drv
);
    logic [WIDTH-1:0] tail_w;

    xcvr_ab_reg #(.W(WIDTH)) u_ab (
        .clk  (clk),
        .rst_n(rst_n),
        .stb  (ab_stb),
        .ce_n (ab_ce_n),
        .d    (a_in),
        .q    (b_out)
    );

    xcvr_ba_chain #(.W(WIDTH), .DEPTH(CHAIN)) u_chain (
        .clk  (clk),
        .rst_n(rst_n),
        .stb  (ba_shift_stb),
        .ce_n (ba_ce_n),
        .d    (b_in),
        .tail (tail_w)
    );

    xcvr_ba_out #(.W(WIDTH)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (ba_out_stb),
        .ce_n      (ba_ce_n),
        .direct    (ba_direct),
        .b_word    (b_in),
        .chain_tail(tail_w),
        .q         (a_out)
    );

    // R7: drive flags follow the active-low enables
    assign b_drv = ~ab_oe_n;
    assign a_drv = ~ba_oe_n;

    // R1: outputs leave reset cleared
    a_r1_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (a_out == '0 && b_out == '0));
endmodule

// File: tb/sim_regbus_xcvr.sv
`timescale 1ns/1ps
module sim_regbus_xcvr;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         ab_stb = 0, ab_ce_n = 1, ab_oe_n = 1;
    logic         ba_shift_stb = 0, ba_out_stb = 0, ba_ce_n = 1, ba_oe_n = 1, ba_direct = 0;
    logic [W-1:0] a_out, b_out;
    logic         a_drv, b_drv;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model state
    logic [W-1:0] m_ab = '0, m_fin = '0;
    logic [W-1:0] m_p0 = '0, m_p1 = '0, m_p2 = '0;

    always #4 clk = ~clk;

    regbus_xcvr u0 (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .ab_stb(ab_stb), .ab_ce_n(ab_ce_n),
        .ab_oe_n(ab_oe_n), .b_in(b_in), .ba_shift_stb(ba_shift_stb),
        .ba_out_stb(ba_out_stb), .ba_ce_n(ba_ce_n), .ba_oe_n(ba_oe_n),
        .ba_direct(ba_direct), .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // apply one cycle of inputs, advance the model, then compare after the edge
    task automatic cyc(input logic [W-1:0] a, input logic as, input logic ace, input logic aoe,
                       input logic [W-1:0] b, input logic s1, input logic s2, input logic bce,
                       input logic boe, input logic dir, input string tag_b, input string tag_a);
        logic [W-1:0] np0, np1, np2, nfin, nab;
        a_in = a; ab_stb = as; ab_ce_n = ace; ab_oe_n = aoe;
        b_in = b; ba_shift_stb = s1; ba_out_stb = s2; ba_ce_n = bce; ba_oe_n = boe; ba_direct = dir;
        nab = m_ab; nfin = m_fin; np0 = m_p0; np1 = m_p1; np2 = m_p2;
        if (as && !ace) nab = a;
        if (s2 && !bce) nfin = dir ? b : m_p2;
        if (s1 && !bce) begin np0 = b; np1 = m_p0; np2 = m_p1; end
        #1;
        chk("R7 b_drv", {{(W-1){1'b0}}, b_drv}, {{(W-1){1'b0}}, ~aoe});
        chk("R7 a_drv", {{(W-1){1'b0}}, a_drv}, {{(W-1){1'b0}}, ~boe});
        @(posedge clk);
        m_ab = nab; m_fin = nfin; m_p0 = np0; m_p1 = np1; m_p2 = np2;
        #1;
        chk(tag_b, b_out, m_ab);
        chk(tag_a, a_out, m_fin);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] seed;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 a_out in reset", a_out, '0);
        chk("R1 b_out in reset", b_out, '0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 a_out after release", a_out, '0);
        chk("R1 b_out after release", b_out, '0);

        // R2 load, R3 holds
        cyc(18'h2A5C3, 1, 0, 0, '0, 0, 0, 1, 1, 0, "R2 load", "R6 idle");
        cyc(18'h11111, 1, 1, 0, '0, 0, 0, 1, 1, 0, "R3 ce high", "R6 idle");
        cyc(18'h22222, 0, 0, 0, '0, 0, 0, 1, 1, 0, "R3 no strobe", "R6 idle");
        // R7: drive off, capture continues
        cyc(18'h3FFFF, 1, 0, 1, '0, 0, 0, 1, 0, 0, "R7 capture while undriven", "R6 idle");

        // R4 direct route
        cyc('0, 0, 1, 1, 18'h0BEEF, 0, 1, 0, 1, 1, "R3 idle", "R4 direct load");
        // R5 chain fill: three shifts, lone output strobes never reveal early
        cyc('0, 0, 1, 1, 18'h10001, 1, 0, 0, 1, 0, "R3 idle", "R5 shift 1");
        cyc('0, 0, 1, 1, 18'h20002, 1, 0, 0, 1, 0, "R3 idle", "R5 shift 2");
        cyc('0, 0, 1, 1, 18'h30003, 0, 1, 0, 1, 0, "R3 idle", "R5 two shifts not yet out");
        chk("R5 early tail is zero", a_out, '0);
        cyc('0, 0, 1, 1, 18'h30003, 1, 0, 0, 1, 0, "R3 idle", "R5 shift 3");
        cyc('0, 0, 1, 1, 18'h0, 0, 1, 0, 1, 0, "R3 idle", "R5 latency out");
        chk("R5 first word out", a_out, 18'h10001);
        // R8 both strobes on one edge
        cyc('0, 0, 1, 1, 18'h04444, 1, 1, 0, 1, 0, "R3 idle", "R8 same edge");
        chk("R8 pre-update tail", a_out, 18'h10001);
        cyc('0, 0, 1, 1, 18'h0, 0, 1, 0, 1, 0, "R3 idle", "R8 moved word");
        chk("R8 shifted tail", a_out, 18'h20002);
        // R6 disabled strobes
        cyc('0, 0, 1, 1, 18'h15555, 1, 1, 1, 1, 0, "R3 idle", "R6 blocked both");
        cyc('0, 0, 1, 1, 18'h16666, 1, 0, 0, 1, 0, "R3 idle", "R6 shift after block");
        cyc('0, 0, 1, 1, 18'h0, 0, 1, 0, 1, 0, "R3 idle", "R6 chain intact");
        chk("R6 chain intact", a_out, 18'h30003);
        // R9 select toggles leave chain alone
        cyc('0, 0, 1, 1, 18'h17777, 0, 1, 0, 1, 1, "R3 idle", "R9 direct mid-stream");
        chk("R9 direct word", a_out, 18'h17777);
        cyc('0, 0, 1, 1, 18'h0, 0, 0, 0, 1, 1, "R3 idle", "R9 select flip idle");
        cyc('0, 0, 1, 1, 18'h0, 0, 1, 0, 1, 0, "R3 idle", "R9 chain after select");
        chk("R9 chain after select", a_out, 18'h30003);

        // sweep against bench model
        seed = 32'h1234_5678;
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] ra, rb;
            seed = seed * 32'd1103515245 + 32'd12345; ra = seed[30:13];
            seed = seed * 32'd1103515245 + 32'd12345; rb = seed[30:13];
            seed = seed * 32'd1103515245 + 32'd12345;
            cyc(ra, seed[16], seed[17] & seed[18], seed[19], rb, seed[20], seed[21],
                seed[22] & seed[23], seed[24], seed[25], "R2/R3 sweep b_out", "R5/R8 sweep a_out");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule